// File: doc/BRIEF.md
# NIC interrupt cause and mask controller

This block holds the interrupt state of a network controller. It has a 32-bit cause register and a 32-bit mask. Single-cycle event pulses from the datapath set cause bits. Software drives one write strobe with a 3-bit register select and a 32-bit data word. Through that strobe it can acknowledge causes (write-one-to-clear), inject causes, set or clear mask bits, and program an auto-mask pattern with its enable bit. The block drives one registered level interrupt, which is high while any unmasked cause is pending.

Bit 24 is a summary cause that stands for a group of minor causes: bits 2, 6, 9, 16, 17 and 18. It reads as set whenever any of those bits is set. Acknowledging bit 24 also acknowledges the whole group. Because of this, a minor cause whose own mask bit is clear cannot hold the summary bit set after software has acknowledged it. Bit 31 reads back the current interrupt level. When auto-mask is enabled, an acknowledge write made while the interrupt is high also removes the programmed pattern from the mask.

Register select values: 0 = cause acknowledge, 1 = cause inject, 2 = mask set, 3 = mask clear, 4 = auto-mask pattern, 5 = control (bit 0 = auto-mask enable). Every register update and the interrupt level take effect on the clock edge that samples the write or the event.

Top module: `nic_irq_ctrl`

## Requirements
- R1: An event pulse on any of bits 0..30 sets that cause bit, and the bit is visible on cause_o after the sampling edge. An event on bit 31 is ignored.
- R2: A write with select 0 clears each cause bit written as 1. Cause bits written as 0 keep their value.
- R3: Cause bit 24 reads as 1 whenever any of cause bits 2, 6, 9, 16, 17 or 18 is 1.
- R4: A select-0 write with data bit 24 set also clears cause bits 2, 6, 9, 16, 17 and 18 in the same update.
- R5: A write with select 1 ORs the data bits 0..30 into the cause register. Data bit 31 is ignored. If a minor cause is injected this way, bit 24 reads as set.
- R6: A select-2 write ORs the data into the mask. A select-3 write clears the mask bits written as 1.
- R7: irq_o is a registered level equal to the OR over bits 0..30 of cause AND mask. It updates on the same edge as the registers.
- R8: A minor cause whose own mask bit is 0 does not assert irq_o unless mask bit 24 is 1.
- R9: A select-0 write made while irq_o is 1 and control bit 0 is 1 clears the mask bits given in the pattern register (select 4). When control bit 0 is 0, the mask is left unchanged.
- R10: If an event pulse and a select-0 clear hit the same cause bit in the same cycle, the bit ends up set.
- R11: cause_o bit 31 reads as 1 exactly while irq_o is 1.
- R12: After reset, cause_o, mask_o and irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 32 | Hardware event pulses, one per cause bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| cause_o | output | 32 | Cause register read value, including the summary and asserted bits |
| mask_o | output | 32 | Current mask |
| irq_o | output | 1 | Level interrupt |

## Verification
Both cause_o and mask_o are brought to ports, so a wrong cause or mask bit shows on the edge right after the write or event that caused it. irq_o then goes wrong on that same edge. A summary bit that fails to drop its group shows up one cycle after the acknowledge: a minor bit is still set, and if bit 24 is unmasked, irq_o stays high. A wrong auto-mask decision is visible in mask_o one cycle after the acknowledge write.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    SEL_CAUSE_ACK = 3'd0,
    SEL_CAUSE_INJ = 3'd1,
    SEL_MASK_SET  = 3'd2,
    SEL_MASK_CLR  = 3'd3,
    SEL_AM_PAT    = 3'd4,
    SEL_CTRL      = 3'd5
  } reg_sel_e;

  localparam int unsigned NSEL = 6;

  // Read view of raw cause bits: summary bit forced by any minor cause.
  function automatic logic [DW-1:0] fold_other(input logic [DW-1:0] raw,
                                               input logic [DW-1:0] sub,
                                               input int unsigned  obit);
    logic [DW-1:0] v;
    v = raw;
    if ((raw & sub) != '0) v[obit] = 1'b1;
    return v;
  endfunction

  // Acknowledge vector: clearing the summary bit drags its group along.
  function automatic logic [DW-1:0] widen_ack(input logic [DW-1:0] wdata,
                                              input logic [DW-1:0] sub,
                                              input int unsigned  obit);
    return wdata[obit] ? (wdata | sub) : wdata;
  endfunction
endpackage

// File: rtl/nic_irq_cause.sv
module nic_irq_cause
  import nic_irq_pkg::*;
#(
  parameter logic [DW-1:0] SUB_MASK   = 32'h0007_0244,
  parameter int unsigned   OTHER_BIT  = 24,
  parameter int unsigned   ASSERT_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_pulse,
  input  logic          ack_hit,
  input  logic          inj_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] view_q,
  output logic [DW-1:0] view_nxt
);
  localparam logic [DW-1:0] KEEP = ~(DW'(1) << ASSERT_BIT);

  logic [DW-1:0] raw_q;
  logic [DW-1:0] raw_nxt;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] set_vec;

  assign clr_vec = ack_hit ? widen_ack(wdata, SUB_MASK, OTHER_BIT) : '0;
  assign set_vec = ev_pulse | (inj_hit ? wdata : '0);
  assign raw_nxt = ((raw_q & ~clr_vec) | set_vec) & KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_nxt;
  end

  assign view_q   = fold_other(raw_q,   SUB_MASK, OTHER_BIT);
  assign view_nxt = fold_other(raw_nxt, SUB_MASK, OTHER_BIT);
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask
  import nic_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mset_hit,
  input  logic          mclr_hit,
  input  logic          pat_hit,
  input  logic          ctrl_hit,
  input  logic          ack_hit,
  input  logic          asserted,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] mask_nxt,
  output logic [DW-1:0] pat_q,
  output logic          am_en_q,
  output logic          am_fire
);
  assign am_fire = ack_hit & asserted & am_en_q;

  always_comb begin
    mask_nxt = mask_q;
    if (mset_hit) mask_nxt = mask_nxt | wdata;
    if (mclr_hit) mask_nxt = mask_nxt & ~wdata;
    if (am_fire)  mask_nxt = mask_nxt & ~pat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pat_q   <= '0;
      am_en_q <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      if (pat_hit)  pat_q   <= wdata;
      if (ctrl_hit) am_en_q <= wdata[0];
    end
  end
endmodule

// File: rtl/nic_irq_out.sv
module nic_irq_out
  import nic_irq_pkg::*;
#(
  parameter int unsigned ASSERT_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] view_nxt,
  input  logic [DW-1:0] mask_nxt,
  output logic          irq_q
);
  localparam logic [DW-1:0] KEEP = ~(DW'(1) << ASSERT_BIT);

  logic [DW-1:0] pend_nxt;
  assign pend_nxt = view_nxt & mask_nxt & KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (pend_nxt != '0);
  end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
#(
  parameter int unsigned   AW         = 3,
  parameter logic [DW-1:0] SUB_MASK   = 32'h0007_0244,
  parameter int unsigned   OTHER_BIT  = 24,
  parameter int unsigned   ASSERT_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_pulse,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cause_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [NSEL-1:0] sel_hit;

  for (genvar i = 0; i < NSEL; i++) begin : g_dec
    assign sel_hit[i] = wr_en && (wr_addr == AW'(i));
  end

  logic          ack_hit;
  logic [DW-1:0] view_q;
  logic [DW-1:0] view_nxt;
  logic [DW-1:0] mask_nxt;
  logic [DW-1:0] am_pat;
  logic          am_en;
  logic          am_fire;
  logic          irq_q;

  assign ack_hit = sel_hit[int'(SEL_CAUSE_ACK)];

  nic_irq_cause #(
    .SUB_MASK  (SUB_MASK),
    .OTHER_BIT (OTHER_BIT),
    .ASSERT_BIT(ASSERT_BIT)
  ) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_pulse(ev_pulse),
    .ack_hit (ack_hit),
    .inj_hit (sel_hit[int'(SEL_CAUSE_INJ)]),
    .wdata   (wr_data),
    .view_q  (view_q),
    .view_nxt(view_nxt)
  );

  nic_irq_mask u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .mset_hit(sel_hit[int'(SEL_MASK_SET)]),
    .mclr_hit(sel_hit[int'(SEL_MASK_CLR)]),
    .pat_hit (sel_hit[int'(SEL_AM_PAT)]),
    .ctrl_hit(sel_hit[int'(SEL_CTRL)]),
    .ack_hit (ack_hit),
    .asserted(irq_q),
    .wdata   (wr_data),
    .mask_q  (mask_o),
    .mask_nxt(mask_nxt),
    .pat_q   (am_pat),
    .am_en_q (am_en),
    .am_fire (am_fire)
  );

  nic_irq_out #(.ASSERT_BIT(ASSERT_BIT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .view_nxt(view_nxt),
    .mask_nxt(mask_nxt),
    .irq_q   (irq_q)
  );

  assign irq_o = irq_q;

  always_comb begin
    cause_o             = view_q;
    cause_o[ASSERT_BIT] = irq_q;
  end
endmodule

// File: rtl/nic_irq_chk.sv
module nic_irq_chk
  import nic_irq_pkg::*;
#(
  parameter int unsigned   AW         = 3,
  parameter logic [DW-1:0] SUB_MASK   = 32'h0007_0244,
  parameter int unsigned   OTHER_BIT  = 24,
  parameter int unsigned   ASSERT_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ev_pulse,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] cause_o,
  input logic [DW-1:0] mask_o,
  input logic          irq_o,
  input logic [DW-1:0] am_pat,
  input logic          am_fire
);
  localparam logic [DW-1:0] KEEP = ~(DW'(1) << ASSERT_BIT);
  localparam logic [DW-1:0] NO_OB = ~(DW'(1) << OTHER_BIT);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic ack_w, mset_w;
  assign ack_w  = wr_en && (wr_addr == AW'(SEL_CAUSE_ACK));
  assign mset_w = wr_en && (wr_addr == AW'(SEL_MASK_SET));

  a_r3_other_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ((cause_o & SUB_MASK) != '0) |-> cause_o[OTHER_BIT]);

  a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> ((cause_o & $past(wr_data) & ~$past(ev_pulse) & KEEP & NO_OB) == '0));

  a_r4_group_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w && wr_data[OTHER_BIT]) |=> ((cause_o & SUB_MASK & ~$past(ev_pulse)) == '0));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_o == ((cause_o & mask_o & KEEP) != '0)));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_pulse & KEEP) != '0) |=> ((cause_o & $past(ev_pulse) & KEEP) == ($past(ev_pulse) & KEEP)));

  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    mset_w |=> ((mask_o & $past(wr_data)) == $past(wr_data)));

  a_r9_automask: assert property (@(posedge clk) disable iff (!rst_n)
    am_fire |=> ((mask_o & $past(am_pat)) == '0));
endmodule

bind nic_irq_ctrl nic_irq_chk #(
  .AW        (AW),
  .SUB_MASK  (SUB_MASK),
  .OTHER_BIT (OTHER_BIT),
  .ASSERT_BIT(ASSERT_BIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ev_pulse(ev_pulse),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .cause_o (cause_o),
  .mask_o  (mask_o),
  .irq_o   (irq_o),
  .am_pat  (am_pat),
  .am_fire (am_fire)
);

// File: tb/nic_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nic_irq_ctrl_bench;
  localparam logic [31:0] GRP  = 32'h0007_0244;
  localparam logic [31:0] LOW  = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev_pulse = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cause_o, mask_o;
  logic        irq_o;

  nic_irq_ctrl u_nic_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model
  logic [31:0] m_raw = '0, m_mask = '0, m_pat = '0;
  logic        m_en = 1'b0, m_irq = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] shown(input logic [31:0] r);
    logic [31:0] s;
    s = r;
    s[24] = r[24] | (|(r & GRP));
    return s;
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq/mask/cause actual %0h_%08h_%08h expected %0h_%08h_%08h",
               tag, act[64], act[63:32], act[31:0], exp[64], exp[63:32], exp[31:0]);
    end
  endtask

  task automatic step(input logic [31:0] ev, input bit we, input logic [2:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] clr, st;
    @(negedge clk);
    ev_pulse = ev; wr_en = we; wr_addr = a; wr_data = d;
    clr = (we && a == 3'd0) ? d : '0;
    if (clr[24]) clr = clr | GRP;
    st  = ev | ((we && a == 3'd1) ? d : '0);
    m_raw = ((m_raw & ~clr) | st) & LOW;
    if (we) begin
      case (a)
        3'd0: if (m_irq && m_en) m_mask = m_mask & ~m_pat;
        3'd2: m_mask = m_mask | d;
        3'd3: m_mask = m_mask & ~d;
        3'd4: m_pat = d;
        3'd5: m_en = d[0];
        default: ;
      endcase
    end
    m_irq = |(shown(m_raw) & m_mask & LOW);
    @(posedge clk);
    exp_q.push_back({m_irq, m_mask, shown(m_raw) | {m_irq, 31'b0}});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [64:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {irq_o, mask_o, cause_o}, e);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R12 reset state", {irq_o, mask_o, cause_o}, 65'd0);

    step(32'h0000_0008, 0, 3'd0, 32'h0, "R1 event bit 3");
    step(32'h8000_0000, 0, 3'd0, 32'h0, "R1 event bit 31 ignored");
    step(32'h0, 1, 3'd2, 32'h0000_0008, "R6 mask set, R7 R11 irq up");
    step(32'h0, 1, 3'd3, 32'h0000_0008, "R6 mask clear, R7 irq down");
    step(32'h0, 1, 3'd2, 32'h0000_0008, "R6 mask set again");
    step(32'h0, 1, 3'd0, 32'h0000_0001, "R2 zeros leave cause");
    step(32'h0, 1, 3'd0, 32'h0000_0008, "R2 clear bit 3");
    step(32'h0, 1, 3'd1, 32'h8000_0010, "R5 inject bit 4, bit 31 ignored");
    step(32'h0000_0040, 0, 3'd0, 32'h0, "R3 R8 masked overrun");
    step(32'h0, 1, 3'd2, 32'h0100_0000, "R8 summary unmasked raises irq");
    step(32'h0, 1, 3'd0, 32'h0100_0000, "R4 summary ack clears group");
    for (int i = 0; i < 32; i++) begin
      if (GRP[i]) begin
        step(32'h1 << i, 0, 3'd0, 32'h0, "R3 minor cause sets summary");
        step(32'h0, 1, 3'd0, 32'h0100_0000, "R4 group cleared");
      end
    end
    step(32'h0, 1, 3'd1, 32'h0002_0000, "R5 inject minor cause");
    step(32'h0, 1, 3'd0, 32'h0002_0000, "R2 ack minor leaves summary only if others");
    step(32'h0000_0010, 1, 3'd0, 32'h0000_0010, "R10 event beats clear");
    step(32'h0, 1, 3'd4, 32'h0000_0010, "R9 pattern");
    step(32'h0, 1, 3'd2, 32'h0000_0010, "R9 unmask bit 4, irq up");
    step(32'h0, 1, 3'd0, 32'h0000_0000, "R9 disabled, mask kept");
    step(32'h0, 1, 3'd5, 32'h0000_0001, "R9 enable");
    step(32'h0, 1, 3'd0, 32'h0000_0000, "R9 auto-mask fires");
    step(32'h0, 1, 3'd0, 32'h0000_0000, "R9 idle ack while low");
    step(32'h0, 1, 3'd2, 32'h0000_0010, "R7 R11 unmask again");
    step(32'h0, 1, 3'd0, 32'h0000_0010, "R9 ack with auto-mask");
    step(32'h0, 0, 3'd0, 32'h0, "R7 idle");
    step(32'h0, 0, 3'd0, 32'h0, "R7 idle");
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule